// File: doc/BRIEF.md
# Reseeded Twisted-Ring Test Pattern Generator

This block is a pattern source for test-per-clock built-in self-test. An n-bit register feeds the inputs of the circuit under test directly, with no logic between them. A 2-to-1 multiplexer and an inverter sit on the register's serial input. They let the same register load a seed bit, run as a ring counter, or run as a twisted-ring (Johnson) counter. This keeps the critical functional paths free of mapping logic.

A controller with Load, Twist and Shift phases takes one seed at a time. It shifts the seed in serially over n cycles, from a small on-chip store or from a slow external tester port. It then runs n rounds of 2n twist steps plus one shift step, which presents 2n²+n patterns for that seed. It then moves to the next seed. After the last seed it pulses `done` and waits for the next `start`.

Top module: `twisted_ring_tpg`

## Requirements
- R1: A synchronous active-high `rst` clears `pattern` to zero, drives `pattern_valid`, `done` and `seed_req` low, and returns the controller to idle at seed index 0.
- R2: A seed is taken one bit per accepted load cycle, most significant bit first. After n accepted bits, the first valid pattern equals the seed exactly.
- R3: In a twist step, the next pattern is the current one shifted one place toward the MSB, with the inverted old MSB entering bit 0.
- R4: In a shift step, the next pattern is the current one shifted one place toward the MSB, with the old MSB entering bit 0 unchanged.
- R5: For each seed, `pattern_valid` stays high for exactly 2n²+n consecutive cycles. These form n rounds, each of 2n twist steps followed by one shift step, and one new pattern is presented every cycle.
- R6: `pattern_valid` is low during every load cycle and while idle.
- R7: When the source captured at start is external, `seed_req` is high for each load cycle. A bit is taken only in a cycle where `seed_valid` is high. While `seed_valid` is low, the register holds its value.
- R8: When the source captured at start is on-chip, `seed_valid` and `seed_bit` are ignored and each load takes exactly n cycles. Seed k is the low n bits of h ^ (h >> 29), where h = (k+1) * 0x9E3779B97F4A7C15 modulo 2^64.
- R9: Seeds 0 to s−1 are used in order. `done` is high for exactly one cycle, the cycle after the last pattern of seed s−1. The block then stays idle with `pattern_valid` low until the next `start`.
- R10: `start` is acted on only while idle. Both `start` and changes on `src_ext` are ignored while a sequence is running, because the source is captured when `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence at seed 0 (honoured only when idle) |
| src_ext | input | 1 | Seed source at start: 1 external serial port, 0 on-chip store |
| seed_bit | input | 1 | External serial seed bit, MSB first |
| seed_valid | input | 1 | External bit is present this cycle |
| seed_req | output | 1 | Controller wants an external seed bit |
| pattern | output | WIDTH | Register contents driving the circuit under test |
| pattern_valid | output | 1 | High in twist and shift cycles |
| done | output | 1 | One-cycle pulse after the final pattern |

## Verification
Two events can coincide. The first is the closing shift step of one seed, which is also the cycle in which the controller moves to the next seed's load or raises `done`. The bench checks the final pattern and the state of `pattern_valid` and `done` in the cycles on either side of that step. The second is a `start` pulse, with a flipped `src_ext`, driven in the middle of a twist run. The bench judges that the running sequence is untouched by checking every following pattern against its own model. External loads get random stalls, and the held register value is compared during each stall.

// File: rtl/twr_pkg.sv
package twr_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LOAD  = 2'd1,
        PH_TWIST = 2'd2,
        PH_SHIFT = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        FEED_SEED  = 2'd0,
        FEED_TWIST = 2'd1,
        FEED_RING  = 2'd2
    } feed_e;

    typedef struct packed {
        logic  step;
        feed_e feed;
    } reg_cmd_t;

    function automatic logic [63:0] seed_word(input int unsigned idx);
        logic [63:0] h;
        h = 64'(idx + 1) * 64'h9E3779B97F4A7C15;
        h = h ^ (h >> 29);
        return h;
    endfunction

    function automatic int unsigned width_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tg_scan_reg.sv
module tg_scan_reg
    import twr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  reg_cmd_t         cmd,
    input  logic             load_bit,
    output logic [WIDTH-1:0] q
);
    logic serial_in;

    // the only logic on the path is this input mux; q drives the CUT directly
    always_comb begin
        case (cmd.feed)
            FEED_SEED:  serial_in = load_bit;
            FEED_TWIST: serial_in = ~q[WIDTH-1];
            default:    serial_in = q[WIDTH-1];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (cmd.step)
            q <= {q[WIDTH-2:0], serial_in};
    end
endmodule

// File: rtl/tg_seed_store.sv
module tg_seed_store
    import twr_pkg::*;
#(
    parameter int WIDTH     = 8,
    parameter int NUM_SEEDS = 4,
    localparam int IDXW = width_bits(NUM_SEEDS),
    localparam int BW   = width_bits(WIDTH)
) (
    input  logic            ext_mode,
    input  logic [IDXW-1:0] seed_idx,
    input  logic [BW-1:0]   bit_idx,
    input  logic            seed_bit,
    output logic            bit_out
);
    logic [WIDTH-1:0] rom [NUM_SEEDS];
    logic [BW-1:0]    pos;
    logic [WIDTH-1:0] word;

    for (genvar g = 0; g < NUM_SEEDS; g++) begin : g_rom
        localparam logic [63:0] HW = seed_word(g);
        assign rom[g] = HW[WIDTH-1:0];
    end

    assign pos     = BW'(WIDTH - 1) - bit_idx;
    assign word    = rom[seed_idx];
    assign bit_out = ext_mode ? seed_bit : word[pos];
endmodule

// File: rtl/tg_ctrl.sv
module tg_ctrl
    import twr_pkg::*;
#(
    parameter int WIDTH     = 8,
    parameter int NUM_SEEDS = 4,
    localparam int IDXW = width_bits(NUM_SEEDS),
    localparam int BW   = width_bits(WIDTH),
    localparam int TW   = width_bits(2 * WIDTH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            src_ext,
    input  logic            seed_valid,
    output phase_e          phase,
    output reg_cmd_t        cmd,
    output logic [IDXW-1:0] seed_idx,
    output logic [BW-1:0]   bit_idx,
    output logic            ext_mode,
    output logic            done
);
    localparam logic [BW-1:0]   LAST_BIT   = BW'(WIDTH - 1);
    localparam logic [BW-1:0]   LAST_ROUND = BW'(WIDTH - 1);
    localparam logic [TW-1:0]   LAST_TW    = TW'(2 * WIDTH - 1);
    localparam logic [IDXW-1:0] LAST_SEED  = IDXW'(NUM_SEEDS - 1);

    logic [TW-1:0] twist_cnt;
    logic [BW-1:0] round_cnt;
    logic          bit_ok;

    assign bit_ok = !ext_mode || seed_valid;

    always_comb begin
        cmd.step = 1'b0;
        cmd.feed = FEED_RING;
        case (phase)
            PH_LOAD:  begin cmd.step = bit_ok; cmd.feed = FEED_SEED;  end
            PH_TWIST: begin cmd.step = 1'b1;   cmd.feed = FEED_TWIST; end
            PH_SHIFT: begin cmd.step = 1'b1;   cmd.feed = FEED_RING;  end
            default:  begin cmd.step = 1'b0;   cmd.feed = FEED_RING;  end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            seed_idx  <= '0;
            bit_idx   <= '0;
            twist_cnt <= '0;
            round_cnt <= '0;
            ext_mode  <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase    <= PH_LOAD;
                        ext_mode <= src_ext;
                        seed_idx <= '0;
                        bit_idx  <= '0;
                    end
                end
                PH_LOAD: begin
                    if (bit_ok) begin
                        if (bit_idx == LAST_BIT) begin
                            bit_idx   <= '0;
                            twist_cnt <= '0;
                            round_cnt <= '0;
                            phase     <= PH_TWIST;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                PH_TWIST: begin
                    twist_cnt <= twist_cnt + 1'b1;
                    if (twist_cnt == LAST_TW)
                        phase <= PH_SHIFT;
                end
                PH_SHIFT: begin
                    twist_cnt <= '0;
                    if (round_cnt == LAST_ROUND) begin
                        round_cnt <= '0;
                        if (seed_idx == LAST_SEED) begin
                            seed_idx <= '0;
                            phase    <= PH_IDLE;
                            done     <= 1'b1;
                        end else begin
                            seed_idx <= seed_idx + 1'b1;
                            phase    <= PH_LOAD;
                        end
                    end else begin
                        round_cnt <= round_cnt + 1'b1;
                        phase     <= PH_TWIST;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/twisted_ring_tpg.sv
module twisted_ring_tpg
    import twr_pkg::*;
#(
    parameter int WIDTH     = 8,
    parameter int NUM_SEEDS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             src_ext,
    input  logic             seed_bit,
    input  logic             seed_valid,
    output logic             seed_req,
    output logic [WIDTH-1:0] pattern,
    output logic             pattern_valid,
    output logic             done
);
    localparam int IDXW = width_bits(NUM_SEEDS);
    localparam int BW   = width_bits(WIDTH);

    phase_e          phase;
    reg_cmd_t        cmd;
    logic [IDXW-1:0] seed_idx;
    logic [BW-1:0]   bit_idx;
    logic            ext_mode;
    logic            load_bit;

    tg_ctrl #(.WIDTH(WIDTH), .NUM_SEEDS(NUM_SEEDS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .src_ext    (src_ext),
        .seed_valid (seed_valid),
        .phase      (phase),
        .cmd        (cmd),
        .seed_idx   (seed_idx),
        .bit_idx    (bit_idx),
        .ext_mode   (ext_mode),
        .done       (done)
    );

    tg_seed_store #(.WIDTH(WIDTH), .NUM_SEEDS(NUM_SEEDS)) u_store (
        .ext_mode (ext_mode),
        .seed_idx (seed_idx),
        .bit_idx  (bit_idx),
        .seed_bit (seed_bit),
        .bit_out  (load_bit)
    );

    tg_scan_reg #(.WIDTH(WIDTH)) u_reg (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .load_bit (load_bit),
        .q        (pattern)
    );

    assign pattern_valid = (phase == PH_TWIST) || (phase == PH_SHIFT);
    assign seed_req      = (phase == PH_LOAD) && ext_mode;
endmodule

// File: rtl/twr_tpg_checker.sv
module twr_tpg_checker #(
    parameter int WIDTH     = 8,
    parameter int NUM_SEEDS = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             seed_valid,
    input logic             seed_req,
    input logic [WIDTH-1:0] pattern,
    input logic             pattern_valid,
    input logic             done
);
    localparam int PPS = 2 * WIDTH * WIDTH + WIDTH;

    logic [31:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)
            run_len <= '0;
        else if (pattern_valid)
            run_len <= run_len + 1;
        else
            run_len <= '0;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (pattern == '0 && !pattern_valid && !done && !seed_req)); // R1

    AST_STEP_SHIFTS: assert property (@(posedge clk) disable iff (rst)
        (pattern_valid && $past(pattern_valid) && !$past(rst))
            |-> pattern[WIDTH-1:1] == $past(pattern[WIDTH-2:0])); // R3

    AST_RUN_LEN: assert property (@(posedge clk) disable iff (rst)
        ($fell(pattern_valid) && !$past(rst)) |-> run_len == PPS); // R5

    AST_NO_VALID_IN_LOAD: assert property (@(posedge clk) disable iff (rst)
        seed_req |-> !pattern_valid); // R6

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (seed_req && !seed_valid) |=> $stable(pattern)); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> (!pattern_valid && !seed_req)); // R9
endmodule

bind twisted_ring_tpg twr_tpg_checker #(.WIDTH(WIDTH), .NUM_SEEDS(NUM_SEEDS)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .seed_valid    (seed_valid),
    .seed_req      (seed_req),
    .pattern       (pattern),
    .pattern_valid (pattern_valid),
    .done          (done)
);

// File: tb/tb_twisted_ring_tpg.sv
module tb_twisted_ring_tpg;
    localparam int W = 6;
    localparam int S = 3;
    localparam int P = 2 * W * W + W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         src_ext = 1'b0;
    logic         seed_bit = 1'b0;
    logic         seed_valid = 1'b0;
    logic         seed_req;
    logic [W-1:0] pattern;
    logic         pattern_valid;
    logic         done;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    twisted_ring_tpg #(.WIDTH(W), .NUM_SEEDS(S)) dut (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .src_ext       (src_ext),
        .seed_bit      (seed_bit),
        .seed_valid    (seed_valid),
        .seed_req      (seed_req),
        .pattern       (pattern),
        .pattern_valid (pattern_valid),
        .done          (done)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // R8 seed formula
    function automatic logic [W-1:0] onchip_seed(input int k);
        logic [63:0] h;
        h = 64'(k + 1) * 64'h9E3779B97F4A7C15;
        h = h ^ (h >> 29);
        return h[W-1:0];
    endfunction

    task automatic check_idle_r1();
        chk(pattern == '0, "R1 pattern", 64'(pattern), 64'd0);
        chk(!pattern_valid && !done && !seed_req, "R1 flags",
            64'({pattern_valid, done, seed_req}), 64'd0);
    endtask

    task automatic load_external(input logic [W-1:0] sd);
        for (int i = 0; i < W; i++) begin
            int stalls = $urandom_range(0, 2);
            for (int t = 0; t < stalls; t++) begin
                logic [W-1:0] held = pattern;
                seed_valid = 1'b0;
                seed_bit   = $urandom_range(0, 1);
                @(negedge clk);
                chk(pattern == held, "R7 stall hold", 64'(pattern), 64'(held));
            end
            chk(seed_req && !pattern_valid, "R7/R6 load flags",
                64'({seed_req, pattern_valid}), 64'b10);
            seed_valid = 1'b1;
            seed_bit   = sd[W-1-i];
            @(negedge clk);
        end
        seed_valid = 1'b0;
    endtask

    task automatic load_internal();
        int n = 0;
        while (!pattern_valid && n < 4 * W) begin
            chk(!seed_req, "R8 no request", 64'(seed_req), 64'd0);
            seed_valid = $urandom_range(0, 1);
            seed_bit   = $urandom_range(0, 1);
            @(negedge clk);
            n++;
        end
        chk(n == W, "R8 load length", 64'(n), 64'(W));
    endtask

    task automatic play_seed(input logic [W-1:0] sd, input bit poke_start, input bit last);
        logic [W-1:0] cur = sd;
        string tag = "R2 first pattern";
        for (int k = 0; k < P; k++) begin
            chk(pattern_valid, "R5 valid run", 64'(pattern_valid), 64'd1);
            chk(pattern == cur, tag, 64'(pattern), 64'(cur));
            chk(!done, "R9 no early done", 64'(done), 64'd0);
            if (poke_start && k == 5) begin
                start   = 1'b1;
                src_ext = ~src_ext;
            end else begin
                start = 1'b0;
            end
            if ((k % (2 * W + 1)) < 2 * W) begin
                cur = {cur[W-2:0], ~cur[W-1]};
                tag = poke_start ? "R10 twist after start" : "R3 twist";
            end else begin
                cur = {cur[W-2:0], cur[W-1]};
                tag = "R4 shift";
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(!pattern_valid, "R5 run ends", 64'(pattern_valid), 64'd0);
        chk(done == last, "R9 done timing", 64'(done), 64'(last));
        if (last) begin
            @(negedge clk);
            chk(!done && !pattern_valid && !seed_req, "R9 idle after done",
                64'({done, pattern_valid, seed_req}), 64'd0);
        end
    endtask

    task automatic run_sequence(input bit ext, input bit poke);
        src_ext = ext;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        src_ext = $urandom_range(0, 1);
        for (int s = 0; s < S; s++) begin
            logic [W-1:0] sd;
            if (ext) begin
                sd = W'($urandom);
                load_external(sd);
            end else begin
                sd = onchip_seed(s);
                load_internal();
            end
            play_seed(sd, poke && s == 1, s == S - 1);
        end
        repeat (3) @(negedge clk);
        chk(!pattern_valid && !seed_req, "R9 stays idle",
            64'({pattern_valid, seed_req}), 64'd0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check_idle_r1();
        rst = 1'b0;
        @(negedge clk);
        check_idle_r1();

        run_sequence(1'b0, 1'b0);
        run_sequence(1'b1, 1'b1);
        run_sequence(1'b0, 1'b1);

        // reset in the middle of a twist run
        src_ext = 1'b0;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (W + 7) @(negedge clk);
        chk(pattern_valid, "R5 running before reset", 64'(pattern_valid), 64'd1);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_idle_r1();
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check_idle_r1();

        run_sequence(1'b1, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule